// File: doc/BRIEF.md
# Pixel Region Latency Buffer

This block keeps the hit data of one square group of sixteen pixels while a level-1 trigger decision is pending. In each bunch crossing any pixel of the group may report a hit together with a 4-bit time-over-threshold code. When at least one pixel reports a hit, the crossing takes a single slot from a small pool that all sixteen pixels share. The slot stores one 10-bit crossing tag for the whole group and a 64-bit payload that holds one amplitude nibble per pixel.

The crossing number comes in from an external 10-bit counter that advances once per clock. A trigger pulse names the crossing that lies exactly one latency behind the current one. Every stored slot with that tag is marked for readout and later leaves through a valid/ready column port, one slot per accepted transfer. A slot that is not marked is released when its age reaches the programmed latency. When every slot is in use, a new hit crossing is discarded and an overflow flag and a saturating counter record the loss.

Top module: `pr_latbuf`

## Requirements
- R1: After reset `col_valid_o` is 0, `ovf_flag_o` is 0 and `ovf_count_o` is 0, and the pool is empty.
- R2: In a clock with at least one bit of `hit_i` set and a free slot, exactly one slot is filled. Its tag is `bx_i`, and payload bits [4p+3:4p] hold `amp_i[4p+3:4p]` for each pixel p whose hit bit is set and 0 for each pixel p whose hit bit is clear.
- R3: In a clock with `trig_i` high, every stored, unmarked slot whose tag equals (`bx_i` − `lat_i`) mod 1024 becomes marked for readout. No other slot is marked.
- R4: An unmarked slot is released at the clock edge where (`bx_i` − tag) mod 1024 is at least `lat_i`. `lat_i` ranges from 1 to 1023. A slot released at an edge cannot be refilled at that same edge. A trigger that arrives after the release finds nothing.
- R5: A marked slot is never released before it is read. The port shows the marked slot with the lowest index. While `col_valid_o` is high and `col_ready_i` is low, `col_valid_o`, `col_tag_o` and `col_data_o` hold their values.
- R6: A transfer (`col_valid_o` and `col_ready_i` both high) releases the shown slot at that edge. `col_valid_o` is 0 whenever no slot is marked.
- R7: A hit crossing that finds no free slot is dropped. `ovf_flag_o` is set and stays set until reset. `ovf_count_o` counts drops and saturates at its maximum value.
- R8: A new crossing fills the free slot with the lowest index, so two marked crossings leave in the order of their arrival after an empty pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock; one edge per crossing |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 16 | Per-pixel hit strobe for the current crossing |
| amp_i | input | 64 | Per-pixel amplitude nibbles; pixel p at [4p+3:4p] |
| bx_i | input | 10 | Current crossing number |
| lat_i | input | 10 | Trigger latency in crossings (1 to 1023) |
| trig_i | input | 1 | Trigger pulse for crossing bx_i − lat_i |
| col_valid_o | output | 1 | A marked slot is shown on the column port |
| col_ready_i | input | 1 | Column side accepts the shown slot |
| col_tag_o | output | 10 | Crossing tag of the shown slot |
| col_data_o | output | 64 | Amplitude payload of the shown slot |
| ovf_flag_o | output | 1 | Sticky flag: a hit crossing was dropped |
| ovf_count_o | output | 8 | Saturating count of dropped hit crossings |

## Verification
The first pattern is a single crossing with two hit pixels, placed so that the tag wraps past 1023. Non-hit pixels carry nonzero codes, which shows whether payload packing and the modular tag match are both right. Three back-to-back crossings with a trigger for the middle one show whether matching picks one tag out of its neighbours, and a trigger one crossing too late shows the expiry boundary. A full pool probed just before, at and just after the first expiry edge shows where release and refill take place. Two triggered crossings held under backpressure for longer than the latency, and a long run of drops at the maximum latency, test ordering and retention, and counter saturation.

// File: rtl/pr_latbuf_pkg.sv
package pr_latbuf_pkg;
  localparam int NPIX  = 16;
  localparam int AMP_W = 4;
  localparam int TAG_W = 10;
  localparam int PAY_W = NPIX * AMP_W;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [PAY_W-1:0] payload_t;

  // Age of a stored crossing, modulo the tag range.
  function automatic tag_t tag_age(tag_t now, tag_t tag);
    return tag_t'(now - tag);
  endfunction

  // Crossing a trigger refers to.
  function automatic tag_t trig_target(tag_t now, tag_t lat);
    return tag_t'(now - lat);
  endfunction

  // Zero the amplitude nibble of every pixel without a hit.
  function automatic payload_t pack_hits(logic [NPIX-1:0] hit, payload_t amp);
    payload_t r;
    for (int p = 0; p < NPIX; p++)
      r[p*AMP_W +: AMP_W] = hit[p] ? amp[p*AMP_W +: AMP_W] : '0;
    return r;
  endfunction
endpackage

// File: rtl/pr_pick.sv
module pr_pick #(
  parameter int N   = 19,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pr_slot.sv
module pr_slot
  import pr_latbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     alloc_i,
  input  logic     take_i,
  input  logic     trig_i,
  input  tag_t     bx_i,
  input  tag_t     lat_i,
  input  payload_t data_i,
  output logic     valid_o,
  output logic     flag_o,
  output tag_t     tag_o,
  output payload_t data_o,
  output logic     match_o,
  output logic     expire_o
);
  assign match_o  = trig_i && valid_o && !flag_o && (tag_o == trig_target(bx_i, lat_i));
  assign expire_o = valid_o && !flag_o && !match_o && (tag_age(bx_i, tag_o) >= lat_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      flag_o  <= 1'b0;
      tag_o   <= '0;
      data_o  <= '0;
    end else if (alloc_i) begin
      valid_o <= 1'b1;
      flag_o  <= 1'b0;
      tag_o   <= bx_i;
      data_o  <= data_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
      flag_o  <= 1'b0;
    end else if (match_o) begin
      flag_o  <= 1'b1;
    end else if (expire_o) begin
      valid_o <= 1'b0;
    end
  end

  // R8: only a free slot is filled
  a_r8_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !valid_o);
  // R5: a marked slot survives until read
  a_r5_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !take_i) |=> (valid_o && flag_o && $stable(tag_o)));
  // R4: an expired slot is released at that edge
  a_r4_expire_frees: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !valid_o);
  // R6: only a marked slot is read out
  a_r6_take_marked: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> (valid_o && flag_o));
endmodule

// File: rtl/pr_latbuf.sv
module pr_latbuf
  import pr_latbuf_pkg::*;
#(
  parameter int DEPTH = 19,
  parameter int CNT_W = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPIX-1:0]    hit_i,
  input  logic [PAY_W-1:0]   amp_i,
  input  logic [TAG_W-1:0]   bx_i,
  input  logic [TAG_W-1:0]   lat_i,
  input  logic               trig_i,
  output logic               col_valid_o,
  input  logic               col_ready_i,
  output logic [TAG_W-1:0]   col_tag_o,
  output logic [PAY_W-1:0]   col_data_o,
  output logic               ovf_flag_o,
  output logic [CNT_W-1:0]   ovf_count_o
);
  logic [DEPTH-1:0] slot_valid, slot_flag, slot_alloc, slot_take, slot_match, slot_expire;
  tag_t             slot_tag  [DEPTH];
  payload_t         slot_data [DEPTH];

  logic          hit_any, free_any, mark_any, drop_ev, xfer_ev;
  logic [IW-1:0] free_idx, mark_idx, sel_idx, hold_idx;
  logic          hold_v;
  payload_t      packed_hits;

  assign hit_any     = |hit_i;
  assign packed_hits = pack_hits(hit_i, amp_i);

  pr_pick #(.N(DEPTH)) u_free_pick (.req_i(~slot_valid), .any_o(free_any), .idx_o(free_idx));
  pr_pick #(.N(DEPTH)) u_mark_pick (.req_i(slot_flag),   .any_o(mark_any), .idx_o(mark_idx));

  assign drop_ev     = hit_any && !free_any;
  assign sel_idx     = hold_v ? hold_idx : mark_idx;
  assign col_valid_o = hold_v || mark_any;
  assign xfer_ev     = col_valid_o && col_ready_i;
  assign col_tag_o   = slot_tag[sel_idx];
  assign col_data_o  = slot_data[sel_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_alloc[g] = hit_any && free_any && (free_idx == IW'(g));
    assign slot_take[g]  = xfer_ev && (sel_idx == IW'(g));
    pr_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_i  (slot_alloc[g]),
      .take_i   (slot_take[g]),
      .trig_i   (trig_i),
      .bx_i     (bx_i),
      .lat_i    (lat_i),
      .data_i   (packed_hits),
      .valid_o  (slot_valid[g]),
      .flag_o   (slot_flag[g]),
      .tag_o    (slot_tag[g]),
      .data_o   (slot_data[g]),
      .match_o  (slot_match[g]),
      .expire_o (slot_expire[g])
    );
  end

  // Keep the shown slot fixed while the column side stalls.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_idx <= '0;
    end else begin
      hold_v   <= col_valid_o && !col_ready_i;
      hold_idx <= sel_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag_o  <= 1'b0;
      ovf_count_o <= '0;
    end else if (drop_ev) begin
      ovf_flag_o <= 1'b1;
      if (ovf_count_o != '1) ovf_count_o <= ovf_count_o + 1'b1;
    end
  end

  // R7: a drop raises the flag and it never clears
  a_r7_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_ev || ovf_flag_o) |=> ovf_flag_o);
  // R7: counter holds at its ceiling
  a_r7_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count_o == '1) |=> (ovf_count_o == '1));
  // R5: port content is held under backpressure
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid_o && !col_ready_i) |=> (col_valid_o && $stable(col_tag_o) && $stable(col_data_o)));
  // R2: at most one slot is filled per crossing
  a_r2_one_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_alloc));
  // R6: at most one slot leaves per transfer
  a_r6_one_take: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_take));
endmodule

// File: tb/test_pr_latbuf.sv
module test_pr_latbuf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] hit;
  logic [63:0] amp;
  logic [9:0]  bx, lat;
  logic        trig, ready;
  logic        cvalid, oflag;
  logic [9:0]  ctag;
  logic [63:0] cdata;
  logic [7:0]  ocnt;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pr_latbuf i_pr_latbuf (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .amp_i(amp), .bx_i(bx), .lat_i(lat),
    .trig_i(trig), .col_valid_o(cvalid), .col_ready_i(ready), .col_tag_o(ctag),
    .col_data_o(cdata), .ovf_flag_o(oflag), .ovf_count_o(ocnt));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One crossing: edge, settle, next crossing number.
  task automatic tick();
    @(posedge clk); #1;
    bx = bx + 10'd1;
  endtask

  task automatic run_to(input logic [9:0] target);
    while (bx != target) tick();
  endtask

  function automatic logic [63:0] nib(input int p, input logic [3:0] a);
    return 64'(a) << (4 * p);
  endfunction

  task automatic start(input logic [9:0] b, input logic [9:0] l);
    rst_n = 0; hit = '0; amp = '0; trig = 0; ready = 0; lat = l; bx = b;
    tick(); tick();
    rst_n = 1;
    bx = b;
  endtask

  task automatic t_reset();
    start(10'd0, 10'd8);
    chk(cvalid == 0, "R1 valid", 64'(cvalid), 0);
    chk(oflag == 0, "R1 flag", 64'(oflag), 0);
    chk(ocnt == 0, "R1 count", 64'(ocnt), 0);
  endtask

  // Single crossing, tag wraps across 1023.
  task automatic t_single_wrap();
    start(10'd1020, 10'd8);
    amp = {16{4'hF}};
    amp[3:0] = 4'h3; amp[23:20] = 4'hA;
    hit = 16'h0021;
    tick();
    hit = '0; amp = '0;
    run_to(10'd4);
    trig = 1; tick(); trig = 0;
    chk(cvalid == 1, "R3 wrap match valid", 64'(cvalid), 1);
    chk(ctag == 10'd1020, "R2 tag", 64'(ctag), 1020);
    chk(cdata == (nib(0, 4'h3) | nib(5, 4'hA)), "R2 payload zeros for non-hit", cdata,
        nib(0, 4'h3) | nib(5, 4'hA));
    ready = 1; tick(); ready = 0;
    chk(cvalid == 0, "R6 freed after transfer", 64'(cvalid), 0);
  endtask

  // Three neighbours, only the middle is requested; a late trigger finds nothing.
  task automatic t_select();
    start(10'd200, 10'd16);
    hit = 16'h0001; amp = 64'h1; tick();
    hit = 16'h0002; amp = 64'h20; tick();
    hit = 16'h0004; amp = 64'h300; tick();
    hit = '0; amp = '0;
    run_to(10'd217);
    trig = 1; tick(); trig = 0;
    chk(cvalid == 1 && ctag == 10'd201, "R3 picks middle tag", 64'(ctag), 201);
    chk(cdata == nib(1, 4'h2), "R3 middle payload", cdata, nib(1, 4'h2));
    ready = 1; tick(); ready = 0;
    chk(cvalid == 0, "R3 only one slot marked", 64'(cvalid), 0);
    run_to(10'd219);
    trig = 1; tick(); trig = 0;
    chk(cvalid == 0, "R4 late trigger after expiry", 64'(cvalid), 0);
  endtask

  // Full pool around the first expiry edge.
  task automatic t_expiry();
    start(10'd100, 10'd32);
    hit = 16'h8000; amp = 64'h7 << 60;
    for (int i = 0; i < 19; i++) tick();
    chk(ocnt == 0 && oflag == 0, "R7 no drop while free", 64'(ocnt), 0);
    tick();
    chk(ocnt == 1 && oflag == 1, "R7 drop when full", 64'(ocnt), 1);
    hit = '0;
    run_to(10'd131);
    hit = 16'h0010; amp = 64'h50000;
    tick();
    chk(ocnt == 2, "R4 still full before expiry", 64'(ocnt), 2);
    tick();
    chk(ocnt == 3, "R4 no refill at release edge", 64'(ocnt), 3);
    tick();
    chk(ocnt == 3, "R4 refill after release", 64'(ocnt), 3);
    hit = '0; amp = '0;
    run_to(10'd165);
    trig = 1; tick(); trig = 0;
    chk(cvalid == 1 && ctag == 10'd133, "R4 refilled slot tag", 64'(ctag), 133);
    chk(cdata == nib(4, 4'h5), "R4 refilled slot payload", cdata, nib(4, 4'h5));
  endtask

  // Two marked crossings held past the latency under backpressure.
  task automatic t_backpressure();
    logic [9:0] t0;
    start(10'd300, 10'd10);
    hit = 16'h8000; amp = 64'hF << 60; tick();
    hit = 16'h0080; amp = 64'h1 << 28; tick();
    hit = '0; amp = '0;
    run_to(10'd310);
    trig = 1; tick(); tick(); trig = 0;
    t0 = ctag;
    chk(cvalid == 1 && t0 == 10'd300, "R8 oldest shown first", 64'(t0), 300);
    for (int i = 0; i < 20; i++) tick();
    chk(cvalid == 1 && ctag == 10'd300 && cdata == nib(15, 4'hF), "R5 held past latency",
        cdata, nib(15, 4'hF));
    ready = 1; tick();
    chk(cvalid == 1 && ctag == 10'd301, "R5 second marked slot kept", 64'(ctag), 301);
    chk(cdata == nib(7, 4'h1), "R2 second payload", cdata, nib(7, 4'h1));
    tick(); ready = 0;
    chk(cvalid == 0, "R6 empty after two transfers", 64'(cvalid), 0);
  endtask

  // Maximum latency and counter saturation.
  task automatic t_saturate();
    start(10'd0, 10'd1023);
    hit = 16'h0001; amp = 64'h9;
    for (int i = 0; i < 19 + 300; i++) tick();
    hit = '0;
    chk(ocnt == 8'hFF, "R7 count saturates", 64'(ocnt), 255);
    chk(oflag == 1, "R7 flag sticky", 64'(oflag), 1);
    chk(cvalid == 0, "R4 nothing expired or marked at max latency", 64'(cvalid), 0);
  endtask

  initial begin
    t_reset();
    t_single_wrap();
    t_select();
    t_expiry();
    t_backpressure();
    t_saturate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule